// File: doc/BRIEF.md
# Serial Frame Transmitter with Selectable Interrupt Meaning

This block serialises bytes onto an asynchronous serial line. A sender hands a byte to a one-entry transmit data register over a valid/ready stream port. A frame shift register takes that byte and sends it as a start bit, 7 or 8 data bits least significant bit first, an optional parity bit and always two stop bits. An external bit-rate strobe times every bit, and baud generation is left outside the block. The data register moves into the shift register on the first strobe after the shift register runs empty, so a byte that is already waiting goes out right after the second stop bit of the byte before it, with no idle time between the frames.

A small control register holds an enable bit and an interrupt-meaning bit. The enable bit turns on the transmitter, the serial output driver and the transmit interrupt together. The interrupt-meaning bit picks one of two meanings for the interrupt. In end-of-byte mode it means the data register is empty. In end-of-message mode it means the data register and the shift register are both empty. Writing a byte fills the data register, and that clears the interrupt.

Stream rules: `in_ready` is high only while the transmitter is enabled and the data register is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the sender holds `in_valid` and `in_data` and waits. That is the only back-pressure, and it lasts at most until the current frame ends.

Top module: `async_tx`

## Requirements
- R1: After reset the control register reads 00, `txd` is 1, `txd_oe` is 0, `tx_irq` is 0 and `in_ready` is 0.
- R2: While the enable bit (control bit 0) is 0, `txd` is 1, `txd_oe` is 0, `tx_irq` is 0 and `in_ready` is 0. Clearing the enable bit during a frame abandons that frame and empties both registers.
- R3: The interrupt-meaning bit (control bit 1) is written as 0 whenever the written value has bit 0 at 0. Reading `ctrl_q` then returns 00.
- R4: A frame is one start bit of 0, then the data bits least significant bit first, then the parity bit if `fmt_par_en` is 1, then two stop bits of 1. Each bit lasts from one `bit_tick` to the next.
- R5: `fmt_bits8` = 1 sends 8 data bits and `fmt_bits8` = 0 sends `in_data[6:0]`. With `fmt_par_odd` = 0 the data bits and the parity bit together hold an even number of ones. With `fmt_par_odd` = 1 they hold an odd number.
- R6: `in_ready` equals the enable bit AND an empty data register. A byte is accepted when `in_valid` and `in_ready` are both high at a rising clock edge, and `in_ready` is low in the following cycle.
- R7: With control bit 1 = 0, `tx_irq` is high exactly when the block is enabled and the data register is empty, whether or not a frame is being sent.
- R8: With control bit 1 = 1, `tx_irq` is high only when the block is enabled, the data register is empty and no frame is being sent.
- R9: An accepted byte drives `tx_irq` low from the cycle after acceptance.
- R10: A byte waiting in the data register when the second stop bit of a frame ends has its start bit sent at that same tick, with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 2 | Control write value: bit 0 enable, bit 1 end-of-message interrupt |
| ctrl_q | output | 2 | Current control register contents |
| fmt_bits8 | input | 1 | 1: eight data bits, 0: seven |
| fmt_par_en | input | 1 | 1: append a parity bit |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Data register can take a byte |
| in_data | input | 8 | Stream byte |
| txd | output | 1 | Serial data, idles high |
| txd_oe | output | 1 | Output driver enable |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench decodes the line at every bit strobe and compares each frame with the bytes it handed over, under random formats and gaps. A wrong parity sense, a dropped stop bit or a 7/8-bit mix-up would therefore show up as a frame mismatch. Back-to-back bytes are checked for zero idle bits between frames, which catches a design that reloads one strobe late. The interrupt is checked in both meanings while a frame is in flight: an end-of-message design that looked only at the data register would raise it too early. A mid-frame disable and a control write with the enable bit low catch a design that keeps driving the line or keeps the interrupt-meaning bit set.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef struct packed {
    logic bits8;
    logic par_en;
    logic par_odd;
  } fmt_t;

  typedef struct packed {
    logic irq_msg;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output ctrl_t      ctrl
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (we) begin
      ctrl.en      <= wdata[0];
      ctrl.irq_msg <= wdata[1] & wdata[0];
    end
  end

  a_r3_sel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[0]) |=> (ctrl == '0));

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wdata;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && !take) |=> full);

  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && !take) |=> $stable(data));

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  fmt_t              fmt,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] next_frame;
  logic [CNT_W-1:0]   next_len;
  logic               last_bit;

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [DATA_W-1:0] d,
    input fmt_t              f
  );
    logic [FRAME_W-1:0] w;
    logic               p;
    int                 n;
    n    = f.bits8 ? DATA_W : DATA_W - 1;
    w    = '1;
    w[0] = 1'b0;
    p    = f.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        w[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (f.par_en) w[n+1] = p;
    return w;
  endfunction

  always_comb begin
    next_frame = pack_frame(hold_data, fmt);
    next_len   = CNT_W'(DATA_W + 2) + CNT_W'(fmt.bits8) + CNT_W'(fmt.par_en);
  end

  assign last_bit = busy && (cnt == CNT_W'(1));
  assign take     = en && tick && hold_full && (!busy || last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
    end else if (tick) begin
      if (busy && !last_bit) begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        cnt   <= cnt - CNT_W'(1);
      end else if (hold_full) begin
        busy  <= 1'b1;
        shreg <= next_frame;
        cnt   <= next_len;
      end else begin
        busy  <= 1'b0;
        shreg <= '1;
        cnt   <= '0;
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

  a_r4_stop_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt <= CNT_W'(2)) |-> txd);

  a_r10_gapless_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && last_bit && hold_full) |=> (busy && !txd));

  a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

// File: rtl/async_tx_irq.sv
module async_tx_irq (
  input  logic en,
  input  logic msg_mode,
  input  logic hold_full,
  input  logic busy,
  output logic irq
);

  always_comb begin
    irq = 1'b0;
    if (en && !hold_full) irq = msg_mode ? !busy : 1'b1;
  end

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_wdata,
  output logic [1:0]        ctrl_q,
  input  logic              fmt_bits8,
  input  logic              fmt_par_en,
  input  logic              fmt_par_odd,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              txd_oe,
  output logic              tx_irq
);

  ctrl_t             ctrl;
  fmt_t              fmt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              ser;
  logic              wr;

  assign fmt      = '{bits8: fmt_bits8, par_en: fmt_par_en, par_odd: fmt_par_odd};
  assign in_ready = ctrl.en && !hold_full;
  assign wr       = in_valid && in_ready;

  async_tx_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .ctrl  (ctrl)
  );

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.en),
    .wr    (wr),
    .wdata (in_data),
    .take  (take),
    .full  (hold_full),
    .data  (hold_data)
  );

  async_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl.en),
    .tick      (bit_tick),
    .fmt       (fmt),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .busy      (busy),
    .txd       (ser)
  );

  async_tx_irq u_irq (
    .en        (ctrl.en),
    .msg_mode  (ctrl.irq_msg),
    .hold_full (hold_full),
    .busy      (busy),
    .irq       (tx_irq)
  );

  assign ctrl_q = {ctrl.irq_msg, ctrl.en};
  assign txd    = ctrl.en ? ser : 1'b1;
  assign txd_oe = ctrl.en;

  a_r9_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !tx_irq);

  a_r8_msg_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && ctrl_q[1]) |-> (in_ready && txd));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (txd && !txd_oe && !tx_irq && !in_ready));

endmodule

// File: tb/async_tx_test.sv
module async_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [1:0] ctrl_wdata = '0;
  logic [1:0] ctrl_q;
  logic       fmt_bits8 = 1'b1;
  logic       fmt_par_en = 1'b0;
  logic       fmt_par_odd = 1'b0;
  logic       bit_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       txd;
  logic       txd_oe;
  logic       tx_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int div     = 0;
  logic tick_d = 1'b0;

  logic [7:0] exp_q[$];
  bit   dec_on = 1'b0;
  int   st = 0, pos = 0, gap = 0, frames = 0;
  bit   chk_gap = 1'b0;
  logic [11:0] acc;

  always #10 clk = ~clk;

  async_tx uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .fmt_bits8(fmt_bits8), .fmt_par_en(fmt_par_en),
    .fmt_par_odd(fmt_par_odd), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .txd_oe(txd_oe),
    .tx_irq(tx_irq)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    tick_d <= bit_tick;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    div      = (div == 3) ? 0 : div + 1;
    bit_tick = (div == 0);
  end

  function automatic int ones(logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  always @(negedge clk) begin
    if (!dec_on) begin
      st = 0; gap = 0;
    end else if (tick_d) begin
      int n, tot, pbit;
      logic [7:0] e, got;
      n   = fmt_bits8 ? 8 : 7;
      tot = n + (fmt_par_en ? 1 : 0) + 2;
      if (st == 0) begin
        if (txd == 1'b0) begin
          if (chk_gap && frames > 0) check("R10 idle bits between frames", gap, 0);
          st = 1; pos = 0; acc = '1;
        end else gap++;
      end else begin
        acc[pos] = txd;
        pos++;
        if (pos == tot) begin
          if (exp_q.size() == 0) begin
            check("R4 unexpected frame", 1, 0);
          end else begin
            e   = exp_q.pop_front();
            got = '0;
            for (int i = 0; i < n; i++) got[i] = acc[i];
            if (n == 7) e[7] = 1'b0;
            check("R4/R5 data bits", got, e);
            if (fmt_par_en) begin
              pbit = acc[n];
              check("R5 parity", (ones(e) + pbit) % 2, fmt_par_odd ? 1 : 0);
            end
            check("R4 two stop bits", {acc[tot-2], acc[tot-1]}, 3);
          end
          st = 0; gap = 0; frames++;
        end
      end
    end
  end

  task automatic ctrl_write(logic [1:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || st != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 ctrl_q", ctrl_q, 0);
    check("R1 txd", txd, 1);
    check("R1 txd_oe", txd_oe, 0);
    check("R1 tx_irq", tx_irq, 0);
    check("R1 in_ready", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ctrl_write(2'b10);
    check("R3 ctrl_q after write 10", ctrl_q, 0);
    check("R2 txd off", txd, 1);
    check("R2 oe off", txd_oe, 0);
    check("R2 irq off", tx_irq, 0);
    check("R2 ready off", in_ready, 0);

    ctrl_write(2'b01);
    dec_on = 1'b1;
    check("R6 ready when empty", in_ready, 1);
    check("R7 irq when empty", tx_irq, 1);
    check("R2 oe on", txd_oe, 1);

    fmt_bits8 = 1; fmt_par_en = 1; fmt_par_odd = 0;
    send(8'hA5);
    check("R9 irq cleared after write", tx_irq, 0);
    check("R6 ready low when full", in_ready, 0);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R7 irq while frame in flight", tx_irq, 1);
    drain();

    ctrl_write(2'b11);
    check("R8 ctrl_q msg mode", ctrl_q, 3);
    check("R8 irq when all idle", tx_irq, 1);
    send(8'h3C);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R8 irq low while shifting", tx_irq, 0);
    drain();
    check("R8 irq after message end", tx_irq, 1);

    ctrl_write(2'b01);
    fmt_bits8 = 0; fmt_par_en = 1; fmt_par_odd = 1;
    frames = 0; chk_gap = 1'b1;
    send(8'hFF); send(8'h00); send(8'h55); send(8'h2A);
    drain();
    chk_gap = 1'b0;

    for (int seg = 0; seg < 6; seg++) begin
      fmt_bits8   = $urandom_range(0, 1);
      fmt_par_en  = $urandom_range(0, 1);
      fmt_par_odd = $urandom_range(0, 1);
      for (int k = 0; k < 16; k++) begin
        send(8'($urandom));
        repeat ($urandom_range(0, 30)) @(negedge clk);
      end
      drain();
    end

    send(8'h81);
    repeat (10) @(negedge clk);
    dec_on = 1'b0;
    exp_q.delete();
    ctrl_write(2'b00);
    check("R2 txd high after abort", txd, 1);
    check("R2 oe low after abort", txd_oe, 0);
    check("R2 irq low after abort", tx_irq, 0);
    check("R2 ready low after abort", in_ready, 0);
    ctrl_write(2'b01);
    check("R2 data register emptied by disable", in_ready, 1);
    repeat (8) @(negedge clk);
    check("R2 line idle after re-enable", txd, 1);

    summary();
  end

endmodule